// File: doc/BRIEF.md
# Half-Bridge Complementary PWM Generator with Dead-Time

This block drives the two gate-control lines of a half bridge, a high-side line and a low-side line, from a single system clock. When a run begins, the block captures a 6-bit setup word. The low three bits select the switching period. The high three bits select a dead-time. An 8-bit duty value scales the high-side on-time within every period. The low side is the complement of the high side. Each rising edge is held back by the dead-time, so the two lines are never high together. The dead-time therefore comes out of the start of every on-interval.

A run lasts while `run_en` stays high. If the setup word captured at the start is all ones, the block does not switch. It raises `ext_sel` so that the surrounding logic can hand the bridge to outside sources. When `run_en` drops, both drive lines go low, and the next run starts again from the beginning of a period with a new setup capture.

Top module: `pwm_dt_top`

## Requirements
- R1: After reset, `hs_drive`, `ls_drive` and `ext_sel` are all low.
- R2: The switching period is BASE_CLKS/(f+1) clocks, rounded down, where f = `cfg_word[2:0]`. With the default BASE_CLKS of 2000, f=0 gives 2000 clocks and f=7 gives 250 clocks.
- R3: The undelayed high-side on-time H is floor(duty*P/256) clocks, where P is the period. H is limited to P - floor(P/50). The undelayed low side is high for the rest of each period. With duty 0, the low side stays on continuously.
- R4: The dead-time is D = 4*d clocks, where d = `cfg_word[5:3]`. A line rises only after its undelayed request has been high for D consecutive clocks. It falls on the clock edge after its request ends. Take E0 as the edge where `run_en` is first sampled high. Then `hs_drive` is first high after edge E(1+D) whenever H > D.
- R5: With d = 0, `hs_drive` and `ls_drive` change on the same clock edge, and exactly one of them is high on every cycle of a run after its first edge.
- R6: `hs_drive` and `ls_drive` are never high in the same cycle.
- R7: `cfg_word` is captured only at the edge that starts a run. Changes during a run have no effect on the period or the dead-time.
- R8: `duty` is sampled at run start and at the last clock of each period. A new value takes effect from the next period.
- R9: A captured setup word of 6'b111111 holds `ext_sel` high from the start edge until `run_en` is sampled low. Both drive lines stay low during that time.
- R10: At the edge where `run_en` is sampled low, both drive lines go low. A following run restarts at the beginning of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | A rising level starts a run; a low level stops it |
| cfg_word | input | 6 | [2:0] period select, [5:3] dead-time select, all ones selects external mode |
| duty | input | 8 | On-time fraction of the high side, in 1/256 of the period |
| hs_drive | output | 1 | High-side gate control |
| ls_drive | output | 1 | Low-side gate control |
| ext_sel | output | 1 | External-source mode flag |

## Verification
The bench sweeps several period codes, from the longest period (2000 clocks) to the shortest (250 clocks), and pairs them with zero, small and maximum dead-time. This separates errors in the period table from errors in the dead-time scaling.

Three duty values probe the on-time calculation: mid-range duty checks the scaling, full duty on the shortest period checks the 2% low-time clamp, and zero duty checks that the low side stays on without break. A duty change in the middle of a period shows whether the new value waits for the period boundary. A setup-word change during a run shows whether the latch at run start holds.

The all-ones setup word checks external mode. Back-to-back stop and restart checks the output clear and the counter restart.

// File: rtl/pwm_dt_pkg.sv
// Package: shared field layout of the setup word for the PWM generator.
// Assumes the period-select field sits in the low bits and the dead-time
// field above it; the all-ones word is reserved for external mode.
package pwm_dt_pkg;
    localparam int FSEL_W = 3;
    localparam int DSEL_W = 3;
    localparam int CFG_W  = FSEL_W + DSEL_W;

    typedef struct packed {
        logic [DSEL_W-1:0] dsel;
        logic [FSEL_W-1:0] fsel;
    } cfg_t;
endpackage

// File: rtl/pwm_cfg_latch.sv
// Module: captures the setup word at the start of a run and turns it into
// a period length and a dead-time length in clocks. It also tracks run and
// external-mode state.
// Assumes run_en is synchronous to clk; a run starts on a low-to-high level.
module pwm_cfg_latch
    import pwm_dt_pkg::*;
#(
    parameter int BASE_CLKS = 2000,
    parameter int DT_STEP   = 4,
    parameter int CNT_W     = $clog2(BASE_CLKS + 1),
    parameter int DT_W      = $clog2((2**DSEL_W - 1) * DT_STEP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  cfg_t             cfg,
    output logic             running,
    output logic             ext_sel,
    output logic [CNT_W-1:0] period,
    output logic [DT_W-1:0]  dt_cyc
);
    localparam int NCODES = 2**FSEL_W;

    logic             run_q;
    logic             start;
    logic             is_ext;
    logic [CNT_W-1:0] per_tab [NCODES];

    // Period table: one constant entry per frequency code.
    for (genvar k = 0; k < NCODES; k++) begin : g_per
        assign per_tab[k] = CNT_W'(BASE_CLKS / (k + 1));
    end

    assign start  = run_en & ~run_q;
    assign is_ext = (cfg == '1);

    // Run state, external flag and setup capture at run start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            running <= 1'b0;
            ext_sel <= 1'b0;
            period  <= CNT_W'(BASE_CLKS);
            dt_cyc  <= '0;
        end else begin
            run_q   <= run_en;
            running <= run_en & (start ? ~is_ext : running);
            ext_sel <= run_en & (start ? is_ext : ext_sel);
            if (start) begin
                period <= per_tab[cfg.fsel];
                dt_cyc <= DT_W'(cfg.dsel) * DT_W'(DT_STEP);
            end
        end
    end
endmodule

// File: rtl/pwm_period_gen.sv
// Module: period counter and duty comparison. It produces the undelayed
// complementary pair of requests.
// Assumes period >= 2; duty is resampled at every period boundary.
module pwm_period_gen #(
    parameter int CNT_W       = 11,
    parameter int DUTY_W      = 8,
    parameter int MIN_LOW_DIV = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              running,
    input  logic [CNT_W-1:0]  period,
    input  logic [DUTY_W-1:0] duty,
    output logic              raw_hi,
    output logic              raw_lo
);
    localparam int PROD_W = CNT_W + DUTY_W;

    logic [CNT_W-1:0]  cnt;
    logic [DUTY_W-1:0] duty_s;
    logic              wrap;
    logic [PROD_W-1:0] prod;
    logic [CNT_W-1:0]  scaled;
    logic [CNT_W-1:0]  cap;
    logic [CNT_W-1:0]  hi_len;
    logic              in_hi;
    logic              live;

    assign wrap = (cnt == period - CNT_W'(1));

    // Counter runs through one period and restarts; duty is resampled at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            duty_s <= '0;
        end else if (!running) begin
            cnt    <= '0;
            duty_s <= duty;
        end else begin
            cnt <= wrap ? '0 : cnt + CNT_W'(1);
            if (wrap) duty_s <= duty;
        end
    end

    // On-time: scale duty by the period, then clamp to keep the minimum low time.
    always_comb begin
        prod   = PROD_W'(duty_s) * PROD_W'(period);
        scaled = prod[PROD_W-1:DUTY_W];
        cap    = period - (period / CNT_W'(MIN_LOW_DIV));
        hi_len = (scaled > cap) ? cap : scaled;
    end

    assign in_hi  = (cnt < hi_len);
    assign live   = running & run_en;
    assign raw_hi = live & in_hi;
    assign raw_lo = live & ~in_hi;
endmodule

// File: rtl/pwm_dead_band.sv
// Module: delays the rising edge of one drive request by dt_cyc clocks.
// The falling edge passes after one register.
// Assumes dt_cyc is stable while the request is active.
module pwm_dead_band #(
    parameter int DT_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw,
    input  logic [DT_W-1:0] dt_cyc,
    output logic            drive
);
    logic [DT_W-1:0] run_len;

    // Count consecutive request cycles (saturating) and release once the dead-time has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
            drive   <= 1'b0;
        end else if (!raw) begin
            run_len <= '0;
            drive   <= 1'b0;
        end else begin
            drive <= (run_len >= dt_cyc);
            if (run_len < dt_cyc) run_len <= run_len + DT_W'(1);
        end
    end
endmodule

// File: rtl/pwm_dt_top.sv
// Module: complementary half-bridge PWM with dead-time. It joins the setup
// latch, the period generator and one dead-band stage per output.
// Assumes all inputs are synchronous to clk.
module pwm_dt_top
    import pwm_dt_pkg::*;
#(
    parameter int BASE_CLKS   = 2000,
    parameter int DT_STEP     = 4,
    parameter int DUTY_W      = 8,
    parameter int MIN_LOW_DIV = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [DUTY_W-1:0] duty,
    output logic              hs_drive,
    output logic              ls_drive,
    output logic              ext_sel
);
    localparam int CNT_W = $clog2(BASE_CLKS + 1);
    localparam int DT_W  = $clog2((2**DSEL_W - 1) * DT_STEP + 1);
    localparam int NCH   = 2;

    logic             running;
    logic [CNT_W-1:0] period_r;
    logic [DT_W-1:0]  dt_cyc;
    logic [NCH-1:0]   raw_v;
    logic [NCH-1:0]   drv_v;

    pwm_cfg_latch #(
        .BASE_CLKS(BASE_CLKS), .DT_STEP(DT_STEP), .CNT_W(CNT_W), .DT_W(DT_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg(cfg_t'(cfg_word)),
        .running(running), .ext_sel(ext_sel), .period(period_r), .dt_cyc(dt_cyc)
    );

    pwm_period_gen #(
        .CNT_W(CNT_W), .DUTY_W(DUTY_W), .MIN_LOW_DIV(MIN_LOW_DIV)
    ) u_per (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .running(running),
        .period(period_r), .duty(duty), .raw_hi(raw_v[0]), .raw_lo(raw_v[1])
    );

    // One dead-band stage per output channel: index 0 high side, index 1 low side.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_db
        pwm_dead_band #(.DT_W(DT_W)) u_db (
            .clk(clk), .rst_n(rst_n), .raw(raw_v[ch]), .dt_cyc(dt_cyc), .drive(drv_v[ch])
        );
    end

    assign hs_drive = drv_v[0];
    assign ls_drive = drv_v[1];
endmodule

// File: rtl/pwm_dt_checker.sv
// Module: property checks for pwm_dt_top, attached through bind.
// Assumes the synchronous active-low reset is applied at time zero.
module pwm_dt_checker #(
    parameter int CNT_W = 11,
    parameter int DT_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             hs_drive,
    input logic             ls_drive,
    input logic             ext_sel,
    input logic             running,
    input logic [CNT_W-1:0] period,
    input logic [DT_W-1:0]  dt_cyc
);
    AST_NEVER_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_drive && ls_drive)); // R6

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!hs_drive && !ls_drive)); // R10

    AST_EXT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |-> (!hs_drive && !ls_drive)); // R9

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && run_en) |=> ext_sel); // R9

    AST_HS_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_drive) && dt_cyc != '0) |-> !$past(ls_drive)); // R4

    AST_LS_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_drive) && dt_cyc != '0) |-> !$past(hs_drive)); // R4

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && running) |-> ($stable(period) && $stable(dt_cyc))); // R7
endmodule

bind pwm_dt_top pwm_dt_checker #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .hs_drive(hs_drive),
    .ls_drive(ls_drive), .ext_sel(ext_sel), .running(running),
    .period(period_r), .dt_cyc(dt_cyc)
);

// File: tb/tb_pwm_dt_top.sv
`timescale 1ns/1ps
// Bench: the driver pushes expected per-cycle outputs into a queue, and a
// monitor pops and compares them 1 ns after each rising edge.
module tb_pwm_dt_top;
    localparam int BASE = 2000;

    typedef struct {
        logic  hs;
        logic  ls;
        logic  ext;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [5:0] cfg_word = '0;
    logic [7:0] duty = '0;
    logic       hs_drive, ls_drive, ext_sel;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    pwm_dt_top dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_word(cfg_word),
        .duty(duty), .hs_drive(hs_drive), .ls_drive(ls_drive), .ext_sel(ext_sel)
    );

    // Monitor: compare the outputs against the queued expectation after every edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            n_run++;
            if (hs_drive !== it.hs || ls_drive !== it.ls || ext_sel !== it.ext) begin
                n_fail++;
                $display("FAIL %s: actual hs=%b ls=%b ext=%b expected hs=%b ls=%b ext=%b at %0t",
                         it.tag, hs_drive, ls_drive, ext_sel, it.hs, it.ls, it.ext, $time);
            end
        end
    end

    function automatic void push(logic hs, logic ls, logic ext, string tag);
        exp_t it;
        it.hs = hs; it.ls = ls; it.ext = ext; it.tag = tag;
        q.push_back(it);
    endfunction

    function automatic int on_len(int dval, int p);
        int h, cap;
        h   = (dval * p) / 256;
        cap = p - p / 50;
        return (h > cap) ? cap : h;
    endfunction

    // Driver: one run with expected outputs derived from R2..R10; ends with a stop.
    task automatic run_case(input logic [5:0] cfg, input int duty_a, input int duty_b,
                            input int sw_k, input logic [5:0] cfg_alt, input int cfg_k,
                            input int ncyc, input string tag);
        int p, dt, hi_run, lo_run, m, qi, h;
        bit ext, rh, rl, eh, el;
        p   = BASE / (int'(cfg[2:0]) + 1);
        dt  = 4 * int'(cfg[5:3]);
        ext = (cfg == 6'h3f);
        hi_run = 0; lo_run = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (k == 0) begin
                run_en = 1'b1; cfg_word = cfg; duty = 8'(duty_a);
            end
            if (k == sw_k)  duty = 8'(duty_b);
            if (k == cfg_k) cfg_word = cfg_alt;
            if (ext || k == 0) begin
                push(1'b0, 1'b0, ext, tag);
            end else begin
                m  = (k - 1) % p;
                qi = (k - 1) / p;
                h  = on_len((qi * p >= sw_k) ? duty_b : duty_a, p);
                rh = (m < h);
                rl = !rh;
                eh = rh && hi_run >= dt;
                el = rl && lo_run >= dt;
                hi_run = rh ? hi_run + 1 : 0;
                lo_run = rl ? lo_run + 1 : 0;
                push(eh, el, 1'b0, tag);
            end
        end
        @(negedge clk);
        run_en = 1'b0;
        push(1'b0, 1'b0, 1'b0, "R10 stop clears outputs");
        @(negedge clk);
        push(1'b0, 1'b0, 1'b0, "R10 idle after stop");
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state with run_en still low
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            push(1'b0, 1'b0, 1'b0, "R1 reset state");
        end
        // R2 R3 R4: period 500, dead-time 4, half duty
        run_case({3'd1, 3'd3}, 128, 128, 1 << 30, '0, 1 << 30, 1010, "R2/R3/R4 p500 dt4");
        // R5 R3: period 250, zero dead-time, full duty clamped
        run_case({3'd0, 3'd7}, 255, 255, 1 << 30, '0, 1 << 30, 520, "R5/R3 p250 dt0 clamp");
        // R2 R4 R7: period 2000, dead-time 28, setup changed mid-run
        run_case({3'd7, 3'd0}, 64, 64, 1 << 30, {3'd0, 3'd7}, 100, 2100, "R2/R4/R7 p2000 dt28");
        // R8: duty change mid-period waits for the boundary
        run_case({3'd2, 3'd5}, 200, 30, 150, '0, 1 << 30, 700, "R8 p333 duty switch");
        // R3: zero duty keeps the low side on after the dead-time
        run_case({3'd1, 3'd1}, 0, 0, 1 << 30, '0, 1 << 30, 300, "R3 duty zero");
        // R9: all-ones setup selects external mode
        run_case(6'h3f, 128, 128, 1 << 30, '0, 1 << 30, 50, "R9 external mode");
        // R10: immediate restart after the stop above begins a fresh period
        run_case({3'd0, 3'd6}, 100, 100, 1 << 30, '0, 1 << 30, 300, "R10/R2 restart p285");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule